// File: doc/BRIEF.md
# Posted-Write Buffer for a Slow Peripheral

This block sits between a fast 8-bit processor bus and a peripheral that can only be written, and that needs several hundred nanoseconds to take a write. At an 8 MHz bus clock, about 62 ns of each cycle is available for an access. Address decode uses roughly 20 ns of that, which leaves around 42 ns. A peripheral that needs 150 to 350 ns cannot meet that directly.

The processor writes to the block in a single bus cycle with no wait states. The block captures the low address lines and the data byte at the end of that cycle. It then drives them to the peripheral, with a chip-select and a write strobe, for a number of clock cycles set by a parameter. After the strobes drop, the captured address and data stay unchanged for one more cycle, which gives the peripheral its hold time.

The peripheral cannot be read through this block. A `busy` output covers both the strobe window and the tail cycle after it. A write that arrives while `busy` is high is discarded, and it sets a sticky overrun flag.

Top module: `slow_write_poster`

## Requirements
- R1: A synchronous active-high reset clears the captured address and data to zero and drives chip-select, write strobe, `busy` and `overrun` low in the cycle after it.
- R2: A cycle with `bus_sel` and `bus_wr` both high while `busy` is low is accepted. From the next cycle, the captured address and data appear on the peripheral side with `per_cs`, `per_we` and `busy` high.
- R3: After an accepted write, `per_cs` and `per_we` stay high for exactly HOLD_CYCLES consecutive cycles (default 3).
- R4: The captured address and data stay unchanged for the whole strobe window and for one more cycle after it, and `busy` stays high during that tail cycle.
- R5: `busy` is low in the cycle after the tail cycle, and a write offered in that first low cycle is accepted.
- R6: A write offered while `busy` is high is discarded. The peripheral-side address, data and strobe length are unaffected, and `overrun` is high from the next cycle.
- R7: `overrun` stays high until reset, including through later accepted writes.
- R8: Cycles with `bus_sel` low, or with `bus_wr` low (a read attempt), cause no capture, no strobe and no overrun.
- R9: Only the low ADDR_W (default 5) bus address bits are captured into `per_addr`. The upper address bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Decoded select for the peripheral's address range |
| bus_wr | input | 1 | High for a write cycle, low for a read |
| bus_addr | input | BUS_ADDR_W (16) | Processor address bus |
| bus_data | input | DATA_W (8) | Processor write data |
| per_addr | output | ADDR_W (5) | Captured low address bits, sent to the peripheral |
| per_data | output | DATA_W (8) | Captured data, sent to the peripheral |
| per_cs | output | 1 | Peripheral chip-select, active high |
| per_we | output | 1 | Peripheral write strobe, active high |
| busy | output | 1 | High during the strobe window and the tail cycle after it |
| overrun | output | 1 | Sticky flag: a write was discarded while busy |

## Verification
The bench uses address and data values chosen to tell the bits apart:
- An address with all upper bits set and a data byte of zero.
- A mixed address over an alternating byte.
- An address of zero over an all-ones byte.
Together these show whether the upper address bits leak into `per_addr` and whether the data lines are held steady.

A write is injected in the middle of the strobe window, to separate a discarded write from one that corrupts or lengthens the window. A write is offered on the first cycle after `busy` falls, to show that this first free cycle is not lost. Select-only cycles and read cycles are offered while idle, to show that they are ignored without setting `overrun`.

// File: rtl/swp_pkg.sv
package swp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_STROBE = 2'd1,
    PH_TAIL   = 2'd2
  } hold_phase_t;
endpackage

// File: rtl/swp_capture.sv
module swp_capture #(
  parameter int BUS_ADDR_W = 16,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [BUS_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_data,
  output logic [ADDR_W-1:0]     lat_addr,
  output logic [DATA_W-1:0]     lat_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_addr <= '0;
      lat_data <= '0;
    end else if (load) begin
      lat_addr <= bus_addr[ADDR_W-1:0];
      lat_data <= bus_data;
    end
  end
endmodule

// File: rtl/swp_hold_timer.sv
module swp_hold_timer #(
  parameter int HOLD_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic strobe_cs,
  output logic strobe_we,
  output logic busy
);
  import swp_pkg::*;

  localparam int CNT_W = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(HOLD_CYCLES - 1);

  hold_phase_t      phase;
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      remain    <= '0;
      strobe_cs <= 1'b0;
      strobe_we <= 1'b0;
      busy      <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase     <= PH_STROBE;
            remain    <= LOAD_VAL;
            strobe_cs <= 1'b1;
            strobe_we <= 1'b1;
            busy      <= 1'b1;
          end
        end
        PH_STROBE: begin
          if (remain == '0) begin
            phase     <= PH_TAIL;
            strobe_cs <= 1'b0;
            strobe_we <= 1'b0;
          end else begin
            remain <= remain - 1'b1;
          end
        end
        PH_TAIL: begin
          phase <= PH_IDLE;
          busy  <= 1'b0;
        end
        default: begin
          phase     <= PH_IDLE;
          strobe_cs <= 1'b0;
          strobe_we <= 1'b0;
          busy      <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/swp_overrun_flag.sv
module swp_overrun_flag (
  input  logic clk,
  input  logic rst,
  input  logic collide,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (collide) flag <= 1'b1;
  end
endmodule

// File: rtl/slow_write_poster.sv
module slow_write_poster #(
  parameter int BUS_ADDR_W  = 16,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int HOLD_CYCLES = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [BUS_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_data,
  output logic [ADDR_W-1:0]     per_addr,
  output logic [DATA_W-1:0]     per_data,
  output logic                  per_cs,
  output logic                  per_we,
  output logic                  busy,
  output logic                  overrun
);
  logic wr_req, accept, collide;

  assign wr_req  = bus_sel & bus_wr;
  assign accept  = wr_req & ~busy;
  assign collide = wr_req & busy;

  swp_capture #(
    .BUS_ADDR_W(BUS_ADDR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_capture (
    .clk(clk), .rst(rst), .load(accept),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .lat_addr(per_addr), .lat_data(per_data)
  );

  swp_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(accept),
    .strobe_cs(per_cs), .strobe_we(per_we), .busy(busy)
  );

  swp_overrun_flag u_overrun (
    .clk(clk), .rst(rst), .collide(collide), .flag(overrun)
  );
endmodule

// File: rtl/swp_checker.sv
module swp_checker #(
  parameter int BUS_ADDR_W  = 16,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int HOLD_CYCLES = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_sel,
  input logic                  bus_wr,
  input logic [BUS_ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0]     bus_data,
  input logic [ADDR_W-1:0]     per_addr,
  input logic [DATA_W-1:0]     per_data,
  input logic                  per_cs,
  input logic                  per_we,
  input logic                  busy,
  input logic                  overrun
);
  int strobe_len;

  always_ff @(posedge clk) begin
    if (rst)         strobe_len <= 0;
    else if (per_cs) strobe_len <= strobe_len + 1;
    else             strobe_len <= 0;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!per_cs && !per_we && !busy && !overrun && per_addr == '0 && per_data == '0));

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && !busy) |=>
      (per_cs && per_we && busy && per_addr == $past(bus_addr[ADDR_W-1:0]) && per_data == $past(bus_data)));

  assert_strobe_len_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(per_cs) |-> (strobe_len == HOLD_CYCLES));

  assert_strobe_cap_R3: assert property (@(posedge clk) disable iff (rst)
    per_cs |-> (strobe_len < HOLD_CYCLES && per_we));

  assert_stable_R4: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || ($stable(per_addr) && $stable(per_data))));

  assert_tail_busy_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(per_cs) |-> busy);

  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(per_cs) |=> !busy);

  assert_overrun_set_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && busy) |=> overrun);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  assert_ignore_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(bus_sel && bus_wr)) |=> (!per_cs && $stable(per_data) && $stable(overrun)));
endmodule

bind slow_write_poster swp_checker #(
  .BUS_ADDR_W(BUS_ADDR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOLD_CYCLES(HOLD_CYCLES)
) u_swp_checker (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_data(bus_data), .per_addr(per_addr),
  .per_data(per_data), .per_cs(per_cs), .per_we(per_we),
  .busy(busy), .overrun(overrun)
);

// File: tb/tb_slow_write_poster.sv
module tb_slow_write_poster;
  localparam int BAW  = 16;
  localparam int AW   = 5;
  localparam int DW   = 8;
  localparam int HOLD = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [BAW-1:0] bus_addr = '0;
  logic [DW-1:0]  bus_data = '0;
  logic [AW-1:0]  per_addr;
  logic [DW-1:0]  per_data;
  logic per_cs, per_we, busy, overrun;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  slow_write_poster #(
    .BUS_ADDR_W(BAW), .ADDR_W(AW), .DATA_W(DW), .HOLD_CYCLES(HOLD)
  ) dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_data(bus_data), .per_addr(per_addr),
    .per_data(per_data), .per_cs(per_cs), .per_we(per_we),
    .busy(busy), .overrun(overrun)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_idle();
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // drives a write in the current low phase; returns at the negedge after capture
  task automatic post_write(input logic [BAW-1:0] a, input logic [DW-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_data = d;
    @(negedge clk);
    drive_idle();
  endtask

  // follows a running strobe window already in its first cycle; counts it, checks tail and release
  task automatic watch_window(input int already, input logic [AW-1:0] ea, input logic [DW-1:0] ed);
    int n = already;
    while (per_cs && n < 20) begin
      chk("R4", "addr during strobe", int'(per_addr), int'(ea));
      chk("R4", "data during strobe", int'(per_data), int'(ed));
      n++;
      @(negedge clk);
    end
    chk("R3", "strobe length", n, HOLD);
    chk("R3", "we low with cs", int'(per_we), 0);
    chk("R4", "busy in tail", int'(busy), 1);
    chk("R4", "addr in tail", int'(per_addr), int'(ea));
    chk("R4", "data in tail", int'(per_data), int'(ed));
    @(negedge clk);
    chk("R5", "busy released", int'(busy), 0);
  endtask

  task automatic t_reset();
    chk("R1", "cs after reset", int'(per_cs), 0);
    chk("R1", "we after reset", int'(per_we), 0);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "overrun after reset", int'(overrun), 0);
    chk("R1", "data after reset", int'(per_data), 0);
    chk("R1", "addr after reset", int'(per_addr), 0);
  endtask

  task automatic t_basic(input logic [BAW-1:0] a, input logic [DW-1:0] d);
    post_write(a, d);
    chk("R2", "cs after write", int'(per_cs), 1);
    chk("R2", "we after write", int'(per_we), 1);
    chk("R2", "busy after write", int'(busy), 1);
    chk("R9", "low address bits", int'(per_addr), int'(a[AW-1:0]));
    chk("R2", "captured data", int'(per_data), int'(d));
    watch_window(0, a[AW-1:0], d);
  endtask

  task automatic t_ignored();
    logic [DW-1:0] prev_d = per_data;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 16'h0007; bus_data = 8'h3C;
    @(negedge clk);
    drive_idle();
    chk("R8", "read attempt no strobe", int'(per_cs), 0);
    chk("R8", "read attempt no capture", int'(per_data), int'(prev_d));
    bus_sel = 1'b0; bus_wr = 1'b1; bus_data = 8'hC3;
    @(negedge clk);
    drive_idle();
    chk("R8", "unselected no strobe", int'(per_cs), 0);
    chk("R8", "unselected no capture", int'(per_data), int'(prev_d));
    chk("R8", "no overrun", int'(overrun), 0);
  endtask

  task automatic t_overrun();
    post_write(16'h0A09, 8'h5A);
    post_write(16'h0A16, 8'hE7);
    chk("R6", "overrun raised", int'(overrun), 1);
    chk("R6", "dropped addr", int'(per_addr), 5'h09);
    chk("R6", "dropped data", int'(per_data), 8'h5A);
    watch_window(1, 5'h09, 8'h5A);
    post_write(16'h0011, 8'h42);
    chk("R7", "accepted after overrun", int'(per_data), 8'h42);
    chk("R7", "overrun held", int'(overrun), 1);
    watch_window(0, 5'h11, 8'h42);
    chk("R7", "overrun still held", int'(overrun), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R7", "overrun cleared by reset", int'(overrun), 0);
    chk("R1", "data cleared by reset", int'(per_data), 0);
  endtask

  task automatic t_back_to_back();
    post_write(16'h001E, 8'h81);
    while (busy) @(negedge clk);
    post_write(16'h0003, 8'h18);
    chk("R5", "first free cycle accepted", int'(per_cs), 1);
    chk("R5", "second data", int'(per_data), 8'h18);
    chk("R6", "no overrun on free cycle", int'(overrun), 0);
    watch_window(0, 5'h03, 8'h18);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic(16'h1234, 8'hA5);
    t_basic(16'hFFFF, 8'h00);
    t_basic(16'h0000, 8'hFF);
    t_ignored();
    t_overrun();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule